// File: doc/BRIEF.md
# Paged Address Mapper with Mask-Selected Bank Registers

This block turns a 16-bit logical address from a processor core into a 21-bit physical address. The top three logical address bits pick one of eight bank registers, and each register holds an 8-bit bank number. The physical address is that bank number followed by the untouched 13-bit page offset, so every 8 KB logical window can be pointed at any of 256 physical banks. The registered physical address appears one clock after the logical address is presented.

The bank registers are loaded and read back through an 8-bit selection mask rather than an index. A load copies the accumulator value into every register whose mask bit is set, all in one cycle. A read scans the mask from bit 0 upward, so the register named by the highest set bit wins. If the mask is empty, the accumulator value passes back unchanged. The surrounding core decodes the two data-movement instructions and drives the strobes. Memories and I/O decode sit elsewhere. In the default map the core's zero page lives at logical 0x2000 and its stack in the 256 bytes after it, so page 1 usually points at working RAM.

Top module: `bank_mmu`

## Requirements
- R1: While reset is high, the physical address output and the accumulator output are both zero one clock later. Every bank register resets to 0, and the highest-numbered register resets to the vector bank parameter, whose default is 0.
- R2: The physical address is {bank register selected by logical address bits [15:13], logical address bits [12:0]}. It is 21 bits, with the bank number in bits [20:13].
- R3: The physical address output is registered. It reflects the logical address sampled at the previous rising clock edge and does not change between edges.
- R4: When the write strobe is high, every bank register whose bit is set in the write mask (bit i selects register i) takes the write data in the same clock. Several registers can be loaded at once.
- R5: Registers whose write mask bit is clear, and all registers while the write strobe is low, keep their values.
- R6: When the read strobe is high and the read mask is non-zero, the accumulator output one clock later is the register of the highest set mask bit.
- R7: When the read strobe is high and the read mask is zero, the accumulator output one clock later equals the accumulator input.
- R8: A write, a translation and a read in the same cycle all see the mapping from before the write. The new value is used from the next cycle on.
- R9: When the read strobe is low, the accumulator output one clock later equals the accumulator input, whatever the read mask holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| log_addr_i | input | 16 | Logical address from the core |
| phys_addr_o | output | 21 | Registered physical address |
| wr_en_i | input | 1 | Bank register load strobe |
| wr_mask_i | input | 8 | Registers to load, bit i selects register i |
| wr_bank_i | input | 8 | Bank number to load (accumulator value) |
| rd_en_i | input | 1 | Bank register read strobe |
| rd_mask_i | input | 8 | Registers to read, highest set bit wins |
| acc_i | input | 8 | Current accumulator value |
| acc_o | output | 8 | Registered accumulator result |

## Verification
The hardest case to reach is a single clock edge where a bank register is rewritten while the same page is being translated and read back. Only there does the old-mapping rule of R8 show at the ports. The stimulus drives the load strobe, a logical address in that page and a read mask naming that register together on one falling edge. It then checks both outputs after the next rising edge against the old bank, and after the following edge against the new one. Read priority is probed with masks whose set bits are spread apart, so a scan in the wrong direction returns a different, distinct register value.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int unsigned MMU_LADDR_W = 16;
  localparam int unsigned MMU_SEL_W   = 3;
  localparam int unsigned MMU_BANK_W  = 8;
  localparam int unsigned MMU_VEC_BANK = 0;
endpackage

// File: rtl/mmu_bank_regs.sv
module mmu_bank_regs #(
  parameter int unsigned NUM_PAGES = 8,
  parameter int unsigned BANK_W    = 8,
  parameter int unsigned VEC_BANK  = 0
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [NUM_PAGES-1:0]              wr_mask,
  input  logic [BANK_W-1:0]                 wr_data,
  output logic [NUM_PAGES-1:0][BANK_W-1:0]  banks_o
);
  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_page
    localparam logic [BANK_W-1:0] RST_V =
      (g == NUM_PAGES - 1) ? BANK_W'(VEC_BANK) : '0;
    logic [BANK_W-1:0] bank_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        bank_q <= RST_V;
      end else if (wr_en && wr_mask[g]) begin
        bank_q <= wr_data;
      end
    end

    assign banks_o[g] = bank_q;
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate #(
  parameter  int unsigned LADDR_W   = 16,
  parameter  int unsigned SEL_W     = 3,
  parameter  int unsigned BANK_W    = 8,
  localparam int unsigned NUM_PAGES = 1 << SEL_W,
  localparam int unsigned OFF_W     = LADDR_W - SEL_W,
  localparam int unsigned PADDR_W   = BANK_W + OFF_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [LADDR_W-1:0]                la_i,
  input  logic [NUM_PAGES-1:0][BANK_W-1:0]  banks_i,
  output logic [PADDR_W-1:0]                pa_o
);
  logic [SEL_W-1:0]  page_sel;
  logic [OFF_W-1:0]  page_off;
  logic [BANK_W-1:0] cur_bank;

  assign page_sel = la_i[LADDR_W-1 -: SEL_W];
  assign page_off = la_i[OFF_W-1:0];
  assign cur_bank = banks_i[page_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      pa_o <= '0;
    end else begin
      pa_o <= {cur_bank, page_off};
    end
  end
endmodule

// File: rtl/mmu_mask_reader.sv
module mmu_mask_reader #(
  parameter  int unsigned NUM_PAGES = 8,
  parameter  int unsigned BANK_W    = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              rd_en,
  input  logic [NUM_PAGES-1:0]              rd_mask,
  input  logic [BANK_W-1:0]                 acc_i,
  input  logic [NUM_PAGES-1:0][BANK_W-1:0]  banks_i,
  output logic [NUM_PAGES-1:0]              pick_oh_o,
  output logic [BANK_W-1:0]                 acc_o
);
  logic [NUM_PAGES-1:0] pick_oh;
  logic                 hit;
  logic [BANK_W-1:0]    pick_val;

  // Scan upward; a later set bit overrides an earlier one.
  always_comb begin
    pick_oh = '0;
    hit     = 1'b0;
    for (int i = 0; i < NUM_PAGES; i++) begin
      if (rd_mask[i]) begin
        pick_oh = '0;
        pick_oh[i] = 1'b1;
        hit = 1'b1;
      end
    end
  end

  // AND-OR selection driven by the one-hot pick.
  always_comb begin
    pick_val = '0;
    for (int i = 0; i < NUM_PAGES; i++) begin
      pick_val = pick_val | (banks_i[i] & {BANK_W{pick_oh[i]}});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o <= '0;
    end else if (rd_en && hit) begin
      acc_o <= pick_val;
    end else begin
      acc_o <= acc_i;
    end
  end

  assign pick_oh_o = pick_oh;
endmodule

// File: rtl/bank_mmu.sv
module bank_mmu #(
  parameter  int unsigned LADDR_W   = mmu_pkg::MMU_LADDR_W,
  parameter  int unsigned SEL_W     = mmu_pkg::MMU_SEL_W,
  parameter  int unsigned BANK_W    = mmu_pkg::MMU_BANK_W,
  parameter  int unsigned VEC_BANK  = mmu_pkg::MMU_VEC_BANK,
  localparam int unsigned NUM_PAGES = 1 << SEL_W,
  localparam int unsigned OFF_W     = LADDR_W - SEL_W,
  localparam int unsigned PADDR_W   = BANK_W + OFF_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [LADDR_W-1:0]   log_addr_i,
  output logic [PADDR_W-1:0]   phys_addr_o,
  input  logic                 wr_en_i,
  input  logic [NUM_PAGES-1:0] wr_mask_i,
  input  logic [BANK_W-1:0]    wr_bank_i,
  input  logic                 rd_en_i,
  input  logic [NUM_PAGES-1:0] rd_mask_i,
  input  logic [BANK_W-1:0]    acc_i,
  output logic [BANK_W-1:0]    acc_o
);
  logic [NUM_PAGES-1:0][BANK_W-1:0] bank_tbl;
  logic [NUM_PAGES-1:0]             pick_oh;

  mmu_bank_regs #(
    .NUM_PAGES (NUM_PAGES),
    .BANK_W    (BANK_W),
    .VEC_BANK  (VEC_BANK)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .wr_mask (wr_mask_i),
    .wr_data (wr_bank_i),
    .banks_o (bank_tbl)
  );

  mmu_xlate #(
    .LADDR_W (LADDR_W),
    .SEL_W   (SEL_W),
    .BANK_W  (BANK_W)
  ) u_xlate (
    .clk     (clk),
    .rst     (rst),
    .la_i    (log_addr_i),
    .banks_i (bank_tbl),
    .pa_o    (phys_addr_o)
  );

  mmu_mask_reader #(
    .NUM_PAGES (NUM_PAGES),
    .BANK_W    (BANK_W)
  ) u_reader (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (rd_en_i),
    .rd_mask   (rd_mask_i),
    .acc_i     (acc_i),
    .banks_i   (bank_tbl),
    .pick_oh_o (pick_oh),
    .acc_o     (acc_o)
  );
endmodule

// File: rtl/mmu_checker.sv
module mmu_checker #(
  parameter  int unsigned LADDR_W   = 16,
  parameter  int unsigned SEL_W     = 3,
  parameter  int unsigned BANK_W    = 8,
  localparam int unsigned NUM_PAGES = 1 << SEL_W,
  localparam int unsigned OFF_W     = LADDR_W - SEL_W,
  localparam int unsigned PADDR_W   = BANK_W + OFF_W
) (
  input logic                             clk,
  input logic                             rst,
  input logic [LADDR_W-1:0]               la,
  input logic [PADDR_W-1:0]               pa,
  input logic                             wr_en,
  input logic [NUM_PAGES-1:0]             wr_mask,
  input logic [BANK_W-1:0]                wr_data,
  input logic                             rd_en,
  input logic [NUM_PAGES-1:0]             rd_mask,
  input logic [BANK_W-1:0]                acc_in,
  input logic [BANK_W-1:0]                acc_out,
  input logic [NUM_PAGES-1:0][BANK_W-1:0] banks,
  input logic [NUM_PAGES-1:0]             pick_oh
);
  assert_reset_outputs_R1: assert property (@(posedge clk)
    rst |=> (pa == '0 && acc_out == '0));

  assert_offset_passes_R2: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pa[OFF_W-1:0] == $past(la[OFF_W-1:0]));

  assert_old_mapping_R8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> pa[PADDR_W-1 -: BANK_W] == $past(banks[la[LADDR_W-1 -: SEL_W]]));

  assert_no_write_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(banks));

  for (genvar g = 0; g < NUM_PAGES; g++) begin : g_chk
    assert_mask_load_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_mask[g]) |=> banks[g] == $past(wr_data));
    assert_unmasked_keeps_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_mask[g]) |=> $stable(banks[g]));
  end

  assert_pick_onehot_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pick_oh) && ((rd_mask != '0) == (pick_oh != '0)));

  assert_pick_highest_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_mask != '0) |-> ((rd_mask & ~(pick_oh - 1'b1)) == pick_oh));

  assert_zero_mask_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (!rst && rd_en && rd_mask == '0) |=> acc_out == $past(acc_in));

  assert_idle_read_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (!rst && !rd_en) |=> acc_out == $past(acc_in));
endmodule

bind bank_mmu mmu_checker #(
  .LADDR_W (LADDR_W),
  .SEL_W   (SEL_W),
  .BANK_W  (BANK_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .la      (log_addr_i),
  .pa      (phys_addr_o),
  .wr_en   (wr_en_i),
  .wr_mask (wr_mask_i),
  .wr_data (wr_bank_i),
  .rd_en   (rd_en_i),
  .rd_mask (rd_mask_i),
  .acc_in  (acc_i),
  .acc_out (acc_o),
  .banks   (bank_tbl),
  .pick_oh (pick_oh)
);

// File: tb/test_bank_mmu.sv
module test_bank_mmu;
  localparam int LW = 16;
  localparam int SW = 3;
  localparam int BW = 8;
  localparam int NP = 8;
  localparam int OW = 13;
  localparam int PW = 21;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [LW-1:0] log_addr = '0;
  logic [PW-1:0] phys_addr;
  logic          wr_en = 1'b0;
  logic [NP-1:0] wr_mask = '0;
  logic [BW-1:0] wr_bank = '0;
  logic          rd_en = 1'b0;
  logic [NP-1:0] rd_mask = '0;
  logic [BW-1:0] acc_in = '0;
  logic [BW-1:0] acc_out;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;
  logic [BW-1:0] model [NP];

  always #10 clk = ~clk;

  bank_mmu i_bank_mmu (
    .clk         (clk),
    .rst         (rst),
    .log_addr_i  (log_addr),
    .phys_addr_o (phys_addr),
    .wr_en_i     (wr_en),
    .wr_mask_i   (wr_mask),
    .wr_bank_i   (wr_bank),
    .rd_en_i     (rd_en),
    .rd_mask_i   (rd_mask),
    .acc_i       (acc_in),
    .acc_o       (acc_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] exp_pa(logic [LW-1:0] a);
    return {model[a[LW-1 -: SW]], a[OW-1:0]};
  endfunction

  task automatic write_map(logic [NP-1:0] m, logic [BW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_mask = m; wr_bank = d;
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0;
    for (int i = 0; i < NP; i++) if (m[i]) model[i] = d;
  endtask

  task automatic look(string req, logic [LW-1:0] a);
    @(negedge clk);
    log_addr = a;
    @(negedge clk);
    chk(req, phys_addr, exp_pa(a));
  endtask

  task automatic read_chk(string req, logic en, logic [NP-1:0] m,
                          logic [BW-1:0] acc, logic [BW-1:0] exp);
    @(negedge clk);
    rd_en = en; rd_mask = m; acc_in = acc;
    @(negedge clk);
    chk(req, acc_out, exp);
    rd_en = 1'b0; rd_mask = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1; log_addr = 16'hE123; acc_in = 8'h5A;
    @(negedge clk); @(negedge clk);
    chk("R1 pa in reset", phys_addr, 0);
    chk("R1 acc in reset", acc_out, 0);
    rst = 1'b0; acc_in = '0;
    for (int i = 0; i < NP; i++) model[i] = '0;
    look("R1 page7 reset bank", 16'hE123);
    look("R1 page0 reset bank", 16'h1FFF);
  endtask

  task automatic t_translate();
    for (int i = 0; i < NP; i++) write_map(NP'(1) << i, 8'(8'h31 * i + 8'h07));
    for (int i = 0; i < NP; i++) look("R2 translate", {3'(i), 13'(13'h1ABC ^ i)});
    @(negedge clk); log_addr = 16'h4321;
    @(negedge clk);
    chk("R3 first", phys_addr, exp_pa(16'h4321));
    log_addr = 16'hC00F;
    #2 chk("R3 holds before edge", phys_addr, exp_pa(16'h4321));
    @(negedge clk);
    chk("R3 after edge", phys_addr, exp_pa(16'hC00F));
  endtask

  task automatic t_multi_write();
    write_map(8'b1010_0101, 8'hE7);
    for (int i = 0; i < NP; i++) look("R4 multi load", {3'(i), 13'h0155});
  endtask

  task automatic t_no_write();
    @(negedge clk);
    wr_en = 1'b0; wr_mask = 8'hFF; wr_bank = 8'h99;
    @(negedge clk);
    wr_mask = '0;
    for (int i = 0; i < NP; i++) look("R5 strobe low", {3'(i), 13'h0AAA});
  endtask

  task automatic t_read_priority();
    for (int i = 0; i < NP; i++) write_map(NP'(1) << i, 8'(8'h10 + 8'h13 * i));
    read_chk("R6 mask 26", 1'b1, 8'h26, 8'h00, model[5]);
    read_chk("R6 mask 01", 1'b1, 8'h01, 8'h00, model[0]);
    read_chk("R6 mask FF", 1'b1, 8'hFF, 8'h00, model[7]);
    read_chk("R6 mask 18", 1'b1, 8'h18, 8'h00, model[4]);
  endtask

  task automatic t_read_zero();
    read_chk("R7 zero mask", 1'b1, 8'h00, 8'h3C, 8'h3C);
  endtask

  task automatic t_read_idle();
    read_chk("R9 strobe low", 1'b0, 8'hFF, 8'h77, 8'h77);
  endtask

  task automatic t_same_cycle();
    logic [BW-1:0] old5;
    old5 = model[5];
    @(negedge clk);
    log_addr = 16'hA055;
    wr_en = 1'b1; wr_mask = 8'h20; wr_bank = 8'h5E;
    rd_en = 1'b1; rd_mask = 8'h20; acc_in = 8'h00;
    @(negedge clk);
    chk("R8 pa old map", phys_addr, {old5, 13'h0055});
    chk("R8 read old map", acc_out, old5);
    wr_en = 1'b0; wr_mask = '0;
    model[5] = 8'h5E;
    @(negedge clk);
    chk("R8 pa new map", phys_addr, {8'h5E, 13'h0055});
    chk("R8 read new map", acc_out, 8'h5E);
    rd_en = 1'b0; rd_mask = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_translate();
    t_multi_write();
    t_no_write();
    t_read_priority();
    t_read_zero();
    t_read_idle();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule